// File: doc/BRIEF.md
# Mask-Driven Pixel Resampling Sequencer

This block drives one axis of a programmable scaler. It produces output pixels in batches whose length is set by a kernel-width register. An 8-bit pattern mask chooses, iteration by iteration, whether a fresh source pixel is taken from the input stream before the output pixel is formed. No fixed-point step accumulator is involved. Iterations whose mask bit is clear re-emit the last source pixel taken. No filter arithmetic is done: each output is a copy of the current source pixel.

Source pixels arrive on a valid/ready stream and results leave on another valid/ready stream. The two configuration registers are written through a simple write port with byte enables. A new setting is staged and only takes over at the next batch boundary, so a batch always runs to completion under one configuration. A second instance of the same block can serve the other axis.

Top module: `mask_resampler`

## Requirements
- R1: After reset the kernel-width field is 0 (one iteration per batch) and the pattern is 0. With this configuration `out_valid` is 1, `out_data` is 0 and `in_ready` is 0, so outputs repeat a zero pixel until a source pixel is taken.
- R2: The width register holds width minus one in `cfg_wdata[2:0]`, for widths 1 to 8. Each batch hands over exactly width output pixels, and the next batch begins on the following accepted output with iteration index 0.
- R3: When pattern bit i is 1 on iteration i, an output needs a source pixel. `in_ready` equals `out_ready`, `out_valid` equals `in_valid`, and `out_data` equals `in_data`. The accepted pixel becomes the new held pixel.
- R4: When the pattern bit for the current iteration is 0, `out_valid` is 1 and `out_data` is the held pixel. `in_ready` is 0, and the held pixel is unchanged by the handover.
- R5: Pattern bits at positions at or above the width have no effect on any batch.
- R6: The pattern register (`cfg_sel`=1, `cfg_wdata[7:0]`) is written only when all four `cfg_be` bits are 1. The width register (`cfg_sel`=0) is written only when `cfg_be[0]` is 1. Other writes leave the register unchanged.
- R7: On an iteration that needs a source pixel while `in_valid` is 0, `out_valid` is 0 and the sequencer does not advance.
- R8: A register write during a batch does not affect that batch. The new setting applies from the next batch.
- R9: While `out_ready` is 0, `in_ready` is 0 and neither the iteration nor the held pixel changes.
- R10: Each batch accepts exactly as many source pixels as there are 1 bits in the pattern below the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 width, 1 pattern |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| in_valid | input | 1 | Source pixel valid |
| in_ready | output | 1 | Source pixel taken |
| in_data | input | PIX_W | Source pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel accepted downstream |
| out_data | output | PIX_W | Output pixel |

## Verification
The main check sweeps every width from 1 to 8 against all 256 pattern values. A set bit inside the width, a clear bit and a bit beyond the width each give a different input count and data order, so mis-indexing, a missing width gate or a swapped bit order all show up. Source validity and output readiness are toggled pseudo-randomly over the whole run. Stalls on needed pixels can then be told apart from downstream back-pressure. Directed phases issue partial-byte writes, writes in the middle of a batch, and long stretches with `out_ready` low.

// File: rtl/rsmp_pkg.sv
// Package: shared register select encoding for the resampling sequencer.
// Assumes: one select bit chooses between the two configuration registers.
package rsmp_pkg;
    typedef enum logic {
        SEL_WIDTH   = 1'b0,
        SEL_PATTERN = 1'b1
    } reg_sel_e;

    localparam int CFG_BYTES = 4;
endpackage

// File: rtl/rsmp_cfg_regs.sv
// Module: programmed (staged) configuration registers.
// Holds width-minus-one and the pattern mask as last written by software.
// Assumes: the pattern takes only full-word writes; the width needs byte 0.
module rsmp_cfg_regs
    import rsmp_pkg::*;
#(
    parameter int KW_MAX = 8,
    parameter int IDX_W  = $clog2(KW_MAX)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic                   cfg_sel,
    input  logic [CFG_BYTES-1:0]   cfg_be,
    input  logic [8*CFG_BYTES-1:0] cfg_wdata,
    output logic [IDX_W-1:0]       prog_kw,
    output logic [KW_MAX-1:0]      prog_pat
);
    localparam int UNUSED_W = 8*CFG_BYTES - KW_MAX;

    logic wr_width;
    logic wr_pattern;
    logic unused_bits;

    // Decode which register a write may update.
    always_comb begin
        wr_width   = cfg_we && (reg_sel_e'(cfg_sel) == SEL_WIDTH) && cfg_be[0];
        wr_pattern = cfg_we && (reg_sel_e'(cfg_sel) == SEL_PATTERN) && (&cfg_be);
    end

    // Upper data bits are discarded by design.
    assign unused_bits = ^cfg_wdata[8*CFG_BYTES-1 -: UNUSED_W];

    // Capture the width field.
    always_ff @(posedge clk) begin
        if (!rst_n)        prog_kw <= '0;
        else if (wr_width) prog_kw <= cfg_wdata[IDX_W-1:0];
    end

    // Capture the pattern mask.
    always_ff @(posedge clk) begin
        if (!rst_n)          prog_pat <= '0;
        else if (wr_pattern) prog_pat <= cfg_wdata[KW_MAX-1:0];
    end
endmodule

// File: rtl/rsmp_batch_seq.sv
// Module: batch iteration counter with active configuration.
// Steps the iteration index on each handed-over output and reloads the
// active width and pattern from the staged copy at each batch boundary.
// Assumes: step is asserted only when an output is accepted.
module rsmp_batch_seq #(
    parameter int KW_MAX = 8,
    parameter int IDX_W  = $clog2(KW_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [IDX_W-1:0]  prog_kw,
    input  logic [KW_MAX-1:0] prog_pat,
    output logic [IDX_W-1:0]  idx,
    output logic [IDX_W-1:0]  act_kw,
    output logic [KW_MAX-1:0] act_pat,
    output logic              need
);
    logic [KW_MAX-1:0] in_window;
    logic              last;

    // Build the mask of iteration positions inside the active width.
    for (genvar g = 0; g < KW_MAX; g++) begin : g_win
        assign in_window[g] = (g <= int'(act_kw));
    end

    // Current iteration needs a source pixel when its bit is set and in range.
    always_comb begin
        last = (idx == act_kw);
        need = act_pat[idx] & in_window[idx];
    end

    // Advance or wrap the iteration index.
    always_ff @(posedge clk) begin
        if (!rst_n)         idx <= '0;
        else if (step) begin
            if (last)       idx <= '0;
            else            idx <= idx + 1'b1;
        end
    end

    // Load the staged configuration only at a batch boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_kw  <= '0;
            act_pat <= '0;
        end else if (step && last) begin
            act_kw  <= prog_kw;
            act_pat <= prog_pat;
        end
    end
endmodule

// File: rtl/rsmp_pix_hold.sv
// Module: held source pixel register.
// Keeps the most recently accepted source pixel for repeated output.
// Assumes: capture is a completed input handshake.
module rsmp_pix_hold #(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [PIX_W-1:0] in_data,
    output logic [PIX_W-1:0] hold
);
    // Store the pixel on every accepted source transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold <= '0;
        else if (capture) hold <= in_data;
    end
endmodule

// File: rtl/mask_resampler.sv
// Module: one axis of a pattern-mask resampling sequencer.
// Emits one output per iteration; pulls a source pixel first on iterations
// whose pattern bit is set, otherwise repeats the held pixel.
// Assumes: the source pixel passes straight through on fetch iterations, so
// in_ready depends combinationally on out_ready.
module mask_resampler
    import rsmp_pkg::*;
#(
    parameter int PIX_W  = 16,
    parameter int KW_MAX = 8,
    parameter int IDX_W  = $clog2(KW_MAX)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic                   cfg_sel,
    input  logic [CFG_BYTES-1:0]   cfg_be,
    input  logic [8*CFG_BYTES-1:0] cfg_wdata,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [PIX_W-1:0]       in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [PIX_W-1:0]       out_data
);
    logic [IDX_W-1:0]  prog_kw;
    logic [KW_MAX-1:0] prog_pat;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  act_kw;
    logic [KW_MAX-1:0] act_pat;
    logic              need;
    logic              step;
    logic              capture;
    logic [PIX_W-1:0]  hold;

    rsmp_cfg_regs #(.KW_MAX(KW_MAX), .IDX_W(IDX_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_be   (cfg_be),
        .cfg_wdata(cfg_wdata),
        .prog_kw  (prog_kw),
        .prog_pat (prog_pat)
    );

    rsmp_batch_seq #(.KW_MAX(KW_MAX), .IDX_W(IDX_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .prog_kw (prog_kw),
        .prog_pat(prog_pat),
        .idx     (idx),
        .act_kw  (act_kw),
        .act_pat (act_pat),
        .need    (need)
    );

    rsmp_pix_hold #(.PIX_W(PIX_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .in_data(in_data),
        .hold   (hold)
    );

    // Stream handshakes and output selection.
    always_comb begin
        out_valid = !need || in_valid;
        in_ready  = need && out_ready;
        out_data  = need ? in_data : hold;
        step      = out_valid && out_ready;
        capture   = step && need;
    end
endmodule

// File: rtl/resampler_checks.sv
// Module: property checker for mask_resampler, attached with bind.
// Assumes: reset is held low from time zero for at least one clock.
module resampler_checks #(
    parameter int PIX_W  = 16,
    parameter int KW_MAX = 8,
    parameter int IDX_W  = $clog2(KW_MAX)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [PIX_W-1:0]  in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [PIX_W-1:0]  out_data,
    input logic [IDX_W-1:0]  idx,
    input logic [IDX_W-1:0]  act_kw,
    input logic [KW_MAX-1:0] act_pat,
    input logic [PIX_W-1:0]  hold
);
    p_idx_in_batch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= act_kw);

    p_pass_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (out_valid && out_data == in_data));

    p_hold_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_ready) |=> (hold == $past(hold)));

    p_stall_only_starved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !in_valid);

    p_cfg_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_kw != $past(act_kw) || act_pat != $past(act_pat))
            |-> (idx == '0 && $past(idx) == $past(act_kw)));

    p_no_take_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> !in_ready);
endmodule

bind mask_resampler resampler_checks #(
    .PIX_W(PIX_W), .KW_MAX(KW_MAX), .IDX_W(IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .idx      (idx),
    .act_kw   (act_kw),
    .act_pat  (act_pat),
    .hold     (hold)
);

// File: tb/sim_mask_resampler.sv
// Bench: sweeps all widths and patterns with random stream pressure and
// compares each cycle against a behavioural model built from the requirements.
module sim_mask_resampler;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_W      = 16;
    localparam int KW_MAX     = 8;
    localparam int IDX_W      = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_we;
    logic              cfg_sel;
    logic [3:0]        cfg_be;
    logic [31:0]       cfg_wdata;
    logic              in_valid;
    logic              in_ready;
    logic [PIX_W-1:0]  in_data;
    logic              out_valid;
    logic              out_ready;
    logic [PIX_W-1:0]  out_data;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [IDX_W-1:0]  m_pkw, m_akw, m_idx;
    logic [KW_MAX-1:0] m_ppat, m_apat;
    logic [PIX_W-1:0]  m_hold;
    logic [PIX_W-1:0]  nxt;
    logic [15:0]       lfsr;
    int                b_out, b_in, batches;
    string             batch_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    mask_resampler #(.PIX_W(PIX_W), .KW_MAX(KW_MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, compare before posedge, update model after.
    task automatic cycle(input bit we, input bit sel, input logic [3:0] be,
                         input logic [31:0] wd, input bit rdy_en);
        bit need, ev, stp, o_hs, i_hs;
        int msk;
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_be = be; cfg_wdata = wd;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        in_valid  = lfsr[0] | lfsr[1];
        out_ready = rdy_en & (lfsr[2] | lfsr[3]);
        in_data   = nxt;
        #1;
        need = m_apat[m_idx];
        ev   = !need || in_valid;
        check(out_valid == ev, need ? "R7" : "R4", "out_valid", out_valid, ev);
        check(in_ready == (need && out_ready), out_ready ? "R3" : "R9",
              "in_ready", in_ready, need && out_ready);
        if (ev && out_valid)
            check(out_data == (need ? in_data : m_hold), need ? "R3" : "R4",
                  "out_data", out_data, need ? in_data : m_hold);
        stp  = ev && out_ready;
        o_hs = out_valid && out_ready;
        i_hs = in_valid && in_ready;
        @(posedge clk);
        if (o_hs) b_out++;
        if (i_hs) begin b_in++; nxt = nxt + 1'b1; end
        if (stp) begin
            if (need) m_hold = in_data;
            if (m_idx == m_akw) begin
                msk = (1 << (int'(m_akw) + 1)) - 1;
                check(b_out == int'(m_akw) + 1, batch_tag != "" ? batch_tag : "R2",
                      "outputs per batch", b_out, int'(m_akw) + 1);
                check(b_in == $countones(m_apat & msk[KW_MAX-1:0]),
                      batch_tag != "" ? batch_tag :
                      ((int'(m_apat) & ~msk) != 0 ? "R5" : "R10"),
                      "inputs per batch", b_in, $countones(m_apat & msk[KW_MAX-1:0]));
                b_out = 0; b_in = 0; batches++;
                m_idx = '0; m_akw = m_pkw; m_apat = m_ppat;
            end else begin
                m_idx = m_idx + 1'b1;
            end
        end
        if (we && !sel && be[0])  m_pkw  = wd[IDX_W-1:0];
        if (we && sel && &be)     m_ppat = wd[KW_MAX-1:0];
    endtask

    task automatic run_batches(input int n);
        int target = batches + n;
        for (int k = 0; k < 400 && batches < target; k++) cycle(0, 0, 4'h0, 0, 1);
        check(batches >= target, "R2", "batch completion", batches, target);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog (R2): actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_be = 0; cfg_wdata = 0;
        in_valid = 0; out_ready = 0; in_data = 0;
        m_pkw = 0; m_akw = 0; m_idx = 0; m_ppat = 0; m_apat = 0; m_hold = 0;
        nxt = 16'h0101; lfsr = 16'hACE1; b_out = 0; b_in = 0; batches = 0;
        batch_tag = "";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b1, "R1", "reset out_valid", out_valid, 1);
        check(out_data == '0, "R1", "reset out_data", out_data, 0);
        check(in_ready == 1'b0, "R1", "reset in_ready", in_ready, 0);
        for (int k = 0; k < 8; k++) cycle(0, 0, 4'h0, 0, 1);

        // Exhaustive sweep: every width against every pattern.
        for (int w = 1; w <= KW_MAX; w++) begin
            for (int p = 0; p < 256; p++) begin
                cycle(1, 0, 4'hF, 32'(w - 1), 1);
                cycle(1, 1, 4'hF, 32'hABCD_0000 | 32'(p), 1);
                run_batches(2);
            end
        end

        // R6: partial writes must not change either register.
        cycle(1, 0, 4'hF, 32'd7, 1);
        cycle(1, 1, 4'hF, 32'h0000_000F, 1);
        run_batches(2);
        cycle(1, 1, 4'h7, 32'h0000_00FF, 1);
        cycle(1, 0, 4'hE, 32'h0000_0001, 1);
        batch_tag = "R6";
        run_batches(2);
        batch_tag = "";

        // R8: mid-batch reconfiguration applies only from the next batch.
        cycle(1, 1, 4'hF, 32'h0000_0055, 1);
        run_batches(2);
        for (int k = 0; k < 200 && m_idx != 3'd3; k++) cycle(0, 0, 4'h0, 0, 1);
        check(m_idx == 3'd3, "R8", "reached mid-batch", m_idx, 3);
        cycle(1, 1, 4'hF, 32'h0000_00FF, 0);
        cycle(1, 0, 4'hF, 32'd2, 0);
        batch_tag = "R8";
        run_batches(1);
        batch_tag = "";
        run_batches(2);

        // R9: long back-pressure stretch.
        for (int k = 0; k < 20; k++) cycle(0, 0, 4'h0, 0, 0);
        run_batches(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule